// File: doc/BRIEF.md
# Standby Wake-up Sequencer

This block controls a low-power standby state in which the core clock is gated off. A sleep request made while the block is running stops the internal clock. At the same time a two-bit status output moves to a code that tells board logic the input oscillator may now be halted or retuned.

While in standby the block watches four kinds of wake request. These are a non-maskable interrupt, a prioritised 4-bit level interrupt, a GPIO level request and a set of peripheral interrupt lines. The level and GPIO requests count only while the slow real-time clock is running and only when their level beats the current interrupt mask. Once a request is accepted, a prescaled 8-bit settling counter runs. When it wraps, the clock is switched back on and a one-cycle wake-exception strobe is raised, together with an event code that names the source. No block-bit input exists, because acceptance in standby never consults one.

An active-low reset ends standby at once, skips the settling count and keeps the clock enabled for as long as it is asserted.

Top module: `stby_wake_seq`

## Requirements
- R1: While in standby or settling, `clk_en` is 0 and `status` is 2'b01 (bit 1 low, bit 0 high).
- R2: While running, `clk_en` is 1 and `status` is 2'b00. After reset, `wake_exc` is 0 and `event_code` is 0.
- R3: An asserted `nmi` in standby is always accepted and yields event code 0x1C0.
- R4: After the acceptance edge, the clock is re-enabled 256·2^`presc_sel` cycles later. This is the point where the 8-bit settling counter, advancing once per prescaled tick, wraps from 0xFF to 0x00.
- R5: A level request is accepted only when `rtc_run` is 1 and `irl_lvl` > `imask` (unsigned, strict). Its code is 0x200 + 0x20·(15 − `irl_lvl`).
- R6: A GPIO request (`gpio_req`=1) is accepted only when `rtc_run` is 1 and `gpio_lvl` > `imask`. Its code is `GPIO_CODE` (default 0x600).
- R7: Any set bit of `per_req` is accepted. Its code is 0x400 + 0x20·i, where i is the lowest set bit index.
- R8: Among requests that are accepted in the same cycle, the order of precedence is NMI, level, GPIO, peripheral.
- R9: `wake_exc` is a single-cycle pulse in the first cycle with `clk_en`=1. `event_code` holds its value until the next wake.
- R10: A sleep request is ignored while any request that would be accepted is present.
- R11: Driving `rst_n` low during standby or settling turns the clock on at once, and no `wake_exc` follows.
- R12: Requests that change during settling do not alter the event code latched at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter standby |
| nmi | input | 1 | Non-maskable wake request |
| irl_lvl | input | LVL_W | Level interrupt priority, 0 = none |
| imask | input | LVL_W | Current interrupt mask level |
| rtc_run | input | 1 | Slow real-time clock is running |
| gpio_req | input | 1 | GPIO wake request |
| gpio_lvl | input | LVL_W | Priority of the GPIO request |
| per_req | input | NPER | Peripheral interrupt lines |
| presc_sel | input | PS_W | Settling prescaler, divide by 2^sel |
| clk_en | output | 1 | Core clock enable |
| status | output | 2 | Standby status pair |
| wake_exc | output | 1 | One-cycle wake exception strobe |
| event_code | output | CODE_W | Code of the source that woke the block |

## Verification
The clocked assertions assume that `presc_sel` stays constant while the counter is settling and that requests are sampled as levels, so a request held for just one cycle in standby is enough. The bench changes `presc_sel` only while the block is running. It raises requests at a falling edge and drops them one cycle after acceptance, apart from the R12 case, where a competing request is raised on purpose during settling. The level and GPIO sweeps cover every level and mask pair, both with the slow clock running and with it stopped.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_STBY   = 2'd1,
      ST_SETTLE = 2'd2
   } stby_st_e;

   localparam logic [1:0] STAT_RUN   = 2'b00;
   localparam logic [1:0] STAT_GATED = 2'b01;

   localparam int CODE_NMI      = 'h1C0;
   localparam int CODE_LVL_BASE = 'h200;
   localparam int CODE_PER_BASE = 'h400;
   localparam int CODE_STEP_LG2 = 5;
endpackage

// File: rtl/stby_wake_arb.sv
module stby_wake_arb
   import stby_pkg::*;
#(
   parameter int NPER      = 4,
   parameter int LVL_W     = 4,
   parameter int CODE_W    = 12,
   parameter int GPIO_CODE = 'h600
) (
   input  logic              nmi,
   input  logic [LVL_W-1:0]  irl_lvl,
   input  logic [LVL_W-1:0]  imask,
   input  logic              rtc_run,
   input  logic              gpio_req,
   input  logic [LVL_W-1:0]  gpio_lvl,
   input  logic [NPER-1:0]   per_req,
   output logic              hit,
   output logic [CODE_W-1:0] code
);
   localparam int PAD_W = CODE_W - LVL_W;

   logic              lvl_ok, gpio_ok, per_hit;
   logic [CODE_W-1:0] lvl_code, per_code;
   logic [CODE_W-1:0] per_tab [NPER];

   genvar g;
   generate
      for (g = 0; g < NPER; g++) begin : g_per_code
         assign per_tab[g] = CODE_W'(CODE_PER_BASE + (g << CODE_STEP_LG2));
      end
   endgenerate

   assign lvl_ok  = rtc_run && (irl_lvl > imask);
   assign gpio_ok = rtc_run && gpio_req && (gpio_lvl > imask);
   // ~lvl equals (max level - lvl)
   assign lvl_code = CODE_W'(CODE_LVL_BASE)
                   + ({{PAD_W{1'b0}}, ~irl_lvl} << CODE_STEP_LG2);

   always_comb begin
      per_hit  = 1'b0;
      per_code = '0;
      for (int i = NPER - 1; i >= 0; i--) begin
         if (per_req[i]) begin
            per_hit  = 1'b1;
            per_code = per_tab[i];
         end
      end
   end

   always_comb begin
      hit  = 1'b1;
      if (nmi)          code = CODE_W'(CODE_NMI);
      else if (lvl_ok)  code = lvl_code;
      else if (gpio_ok) code = CODE_W'(GPIO_CODE);
      else if (per_hit) code = per_code;
      else begin
         hit  = 1'b0;
         code = '0;
      end
   end
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
   parameter int CNT_W = 8,
   parameter int PS_W  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] presc_sel,
   output logic            ovf
);
   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] pre_q, lim;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;

   assign lim  = ~({DIV_W{1'b1}} << presc_sel);
   assign tick = (pre_q == lim);
   assign ovf  = run && tick && (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (!run) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (tick) begin
         pre_q <= '0;
         cnt_q <= cnt_q + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))) else $error("tick step"); // R4
   AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt_q)) else $error("count moved without tick"); // R4
endmodule

// File: rtl/stby_wake_seq.sv
module stby_wake_seq
   import stby_pkg::*;
#(
   parameter int NPER      = 4,
   parameter int LVL_W     = 4,
   parameter int CNT_W     = 8,
   parameter int PS_W      = 2,
   parameter int CODE_W    = 12,
   parameter int GPIO_CODE = 'h600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              nmi,
   input  logic [LVL_W-1:0]  irl_lvl,
   input  logic [LVL_W-1:0]  imask,
   input  logic              rtc_run,
   input  logic              gpio_req,
   input  logic [LVL_W-1:0]  gpio_lvl,
   input  logic [NPER-1:0]   per_req,
   input  logic [PS_W-1:0]   presc_sel,
   output logic              clk_en,
   output logic [1:0]        status,
   output logic              wake_exc,
   output logic [CODE_W-1:0] event_code
);
   generate
      if (NPER < 1 || NPER > 8) begin : g_bad_nper
         $error("NPER must be 1..8");
      end
      if (PS_W < 1 || PS_W > 3) begin : g_bad_ps
         $error("PS_W must be 1..3");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (CODE_W < 12 || LVL_W > 4 || LVL_W < 1) begin : g_bad_code
         $error("CODE_W must be >= 12 and LVL_W 1..4");
      end
   endgenerate

   stby_st_e          state_q;
   logic [CODE_W-1:0] pend_q;
   logic              hit, ovf;
   logic [CODE_W-1:0] code;

   stby_wake_arb #(
      .NPER(NPER), .LVL_W(LVL_W), .CODE_W(CODE_W), .GPIO_CODE(GPIO_CODE)
   ) u_arb (
      .nmi(nmi), .irl_lvl(irl_lvl), .imask(imask), .rtc_run(rtc_run),
      .gpio_req(gpio_req), .gpio_lvl(gpio_lvl), .per_req(per_req),
      .hit(hit), .code(code)
   );

   stby_settle_cnt #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(state_q == ST_SETTLE),
      .presc_sel(presc_sel), .ovf(ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_RUN;
         pend_q     <= '0;
         wake_exc   <= 1'b0;
         event_code <= '0;
      end else begin
         wake_exc <= 1'b0;
         unique case (state_q)
            ST_RUN: if (sleep_req && !hit) state_q <= ST_STBY;
            ST_STBY: if (hit) begin
               state_q <= ST_SETTLE;
               pend_q  <= code;
            end
            ST_SETTLE: if (ovf) begin
               state_q    <= ST_RUN;
               wake_exc   <= 1'b1;
               event_code <= pend_q;
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign clk_en = (state_q == ST_RUN);
   assign status = clk_en ? STAT_RUN : STAT_GATED;

   AST_GATED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> (status == 2'b01 && !wake_exc)) else $error("gated status"); // R1
   AST_RUN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> (status == 2'b00)) else $error("run status"); // R2
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_exc |=> !wake_exc) else $error("strobe too long"); // R9
   AST_PULSE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      wake_exc |-> (clk_en && !$past(clk_en))) else $error("strobe not at clock restart"); // R9
   AST_SLEEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && sleep_req && hit) |=> clk_en) else $error("sleep taken with wake pending"); // R10
   AST_SETTLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE && $past(state_q) == ST_SETTLE) |-> $stable(pend_q)) else $error("latched code moved"); // R12
endmodule

// File: tb/tb_stby_wake_seq.sv
module tb_stby_wake_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0, nmi = 1'b0, rtc_run = 1'b0, gpio_req = 1'b0;
   logic [3:0] irl_lvl = '0, imask = '0, gpio_lvl = '0;
   logic [3:0] per_req = '0;
   logic [1:0] presc_sel = '0;
   logic       clk_en, wake_exc;
   logic [1:0] status;
   logic [11:0] event_code;
   int errs = 0, checks = 0;

   always #10 clk = ~clk;

   stby_wake_seq dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .nmi(nmi),
      .irl_lvl(irl_lvl), .imask(imask), .rtc_run(rtc_run), .gpio_req(gpio_req),
      .gpio_lvl(gpio_lvl), .per_req(per_req), .presc_sel(presc_sel),
      .clk_en(clk_en), .status(status), .wake_exc(wake_exc), .event_code(event_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      nmi = 0; gpio_req = 0; per_req = '0; irl_lvl = '0; gpio_lvl = '0;
   endtask

   task automatic go_sleep();
      sleep_req = 1;
      @(negedge clk);
      sleep_req = 0;
      chk(clk_en == 0 && status == 2'b01, "R1 standby entry", {clk_en, status}, 1);
   endtask

   // inputs already driven; acceptance at next edge, then wait for strobe
   task automatic wait_wake(output int n);
      n = 0;
      @(negedge clk); n++;
      clear_in();
      while (!wake_exc && n < 5000) begin
         if (n == 10) chk(clk_en == 0 && status == 2'b01, "R1 settling", {clk_en, status}, 1);
         @(negedge clk); n++;
      end
   endtask

   task automatic try_wake(input bit exp_hit, input int exp_code, input string req);
      int n;
      if (exp_hit) begin
         wait_wake(n);
         chk(wake_exc == 1 && event_code == exp_code, req, event_code, exp_code);
      end else begin
         @(negedge clk);
         clear_in();
         @(negedge clk);
         chk(clk_en == 0 && wake_exc == 0, req, clk_en, 0);
      end
   endtask

   task automatic ensure_stby();
      if (clk_en) go_sleep();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int n;
      #5;
      chk(clk_en == 1 && status == 2'b00, "R2 clock on in reset", {clk_en, status}, 4);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(clk_en == 1 && status == 2'b00 && wake_exc == 0 && event_code == 0,
          "R2 reset state", event_code, 0);

      // R4 latency for every prescaler setting, NMI source (R3)
      for (int s = 0; s < 4; s++) begin
         presc_sel = 2'(s);
         ensure_stby();
         nmi = 1;
         wait_wake(n);
         chk(n == (256 << s) + 1, "R4 settle latency", n, (256 << s) + 1);
         chk(event_code == 12'h1C0 && clk_en == 1 && status == 2'b00, "R3 nmi code", event_code, 'h1C0);
      end
      presc_sel = 0;

      // R9 strobe width and code hold
      @(negedge clk);
      chk(wake_exc == 0 && event_code == 12'h1C0, "R9 pulse one cycle, code held", wake_exc, 0);

      // R5 level sweep, slow clock running and stopped
      for (int r = 0; r < 2; r++) begin
         for (int l = 0; l < 16; l++) begin
            for (int m = 0; m < 16; m++) begin
               ensure_stby();
               rtc_run = r[0];
               irl_lvl = 4'(l); imask = 4'(m);
               try_wake(r == 1 && l > m, 'h200 + 'h20 * (15 - l), "R5 level qualify/code");
            end
         end
      end

      // R6 GPIO sweep
      for (int r = 0; r < 2; r++) begin
         for (int l = 0; l < 16; l++) begin
            for (int m = 0; m < 16; m++) begin
               ensure_stby();
               rtc_run = r[0];
               gpio_req = 1; gpio_lvl = 4'(l); imask = 4'(m);
               try_wake(r == 1 && l > m, 'h600, "R6 gpio qualify/code");
            end
         end
      end
      imask = 0; rtc_run = 1;

      // R7 every peripheral mask pattern
      for (int p = 1; p < 16; p++) begin
         int lo;
         lo = 0;
         while (!p[lo]) lo++;
         ensure_stby();
         per_req = 4'(p);
         try_wake(1, 'h400 + 'h20 * lo, "R7 peripheral code");
      end

      // R8 precedence
      ensure_stby();
      nmi = 1; irl_lvl = 5; gpio_req = 1; gpio_lvl = 9; per_req = 4'hF;
      try_wake(1, 'h1C0, "R8 nmi first");
      ensure_stby();
      irl_lvl = 5; gpio_req = 1; gpio_lvl = 9; per_req = 4'hF;
      try_wake(1, 'h200 + 'h20 * 10, "R8 level over gpio");
      ensure_stby();
      gpio_req = 1; gpio_lvl = 9; per_req = 4'h4;
      try_wake(1, 'h600, "R8 gpio over peripheral");

      // R10 sleep ignored while a wake is pending
      if (!clk_en) begin nmi = 1; try_wake(1, 'h1C0, "R10 setup"); end
      nmi = 1; sleep_req = 1;
      @(negedge clk);
      sleep_req = 0; nmi = 0;
      chk(clk_en == 1 && status == 2'b00, "R10 sleep with nmi ignored", clk_en, 1);
      per_req = 4'h2; sleep_req = 1;
      @(negedge clk);
      sleep_req = 0; per_req = 0;
      chk(clk_en == 1, "R10 sleep with peripheral ignored", clk_en, 1);
      rtc_run = 0; irl_lvl = 15; sleep_req = 1;
      @(negedge clk);
      sleep_req = 0; irl_lvl = 0; rtc_run = 1;
      chk(clk_en == 0 && status == 2'b01, "R10 unqualified level lets sleep in", clk_en, 0);

      // R12 late request during settling
      ensure_stby();
      per_req = 4'h8;
      @(negedge clk);
      per_req = 0; nmi = 1;
      n = 1;
      while (!wake_exc && n < 5000) begin @(negedge clk); n++; end
      nmi = 0;
      chk(event_code == 12'h460, "R12 code latched at acceptance", event_code, 'h460);

      // R11 reset during settling
      ensure_stby();
      nmi = 1;
      repeat (20) @(negedge clk);
      nmi = 0;
      rst_n = 0;
      #2;
      chk(clk_en == 1 && status == 2'b00, "R11 reset restores clock", {clk_en, status}, 4);
      @(negedge clk);
      rst_n = 1;
      n = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (wake_exc || !clk_en) n++;
      end
      chk(n == 0, "R11 no strobe after reset", n, 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule